// File: doc/BRIEF.md
# Three-Pair Complementary Motor PWM Generator

This block drives a three-phase power stage. It has six outputs arranged as three complementary pairs. One period counter is shared by all pairs. It counts either as a sawtooth (edge-aligned) or as a triangle (center-aligned). Each pair compares the counter against its own duty value to produce a raw level. Dead time is then inserted, so that the high-side and low-side switches of a leg are never on together.

Software programs the block through a simple write port. Period and duty writes land in buffer registers. The buffers are copied into the working registers while the block is stopped, and while it runs they are copied only every N PWM periods (N from 1 to 16). Each copy sets a sticky reload flag.

The dead time, fault mask and counting mode form a setup word that can be written once per reset. An external fault input immediately forces the masked outputs low and latches. A one-cycle pulse at the start of every PWM period serves as an ADC conversion trigger.

Top module: `pwm6_core`

## Requirements
- R1: In edge-aligned mode with period P (register 2) and duty D (registers 3, 4, 5 for pairs 0, 1, 2), with dead time T < D and T < P−D, each period lasts P cycles. The top output `pwm_out[2k]` is high for D−T cycles of each period and the bottom output `pwm_out[2k+1]` is high for P−D−T cycles.
- R2: In center-aligned mode (setup bit 10 = 1), each period lasts 2P cycles. Within it, the top output is high for 2D−T cycles and the bottom output for 2(P−D)−T cycles.
- R3: The two outputs of a pair are never high in the same cycle. After one output goes low, the other stays low for at least T cycles, where T is setup bits 3:0.
- R4: A duty of 0 keeps the top output low and the bottom output high in every cycle. A duty of P or more keeps the top output high and the bottom output low in every cycle.
- R5: While `fault_in` is high, every output whose bit is set in the fault mask (setup bits 9:4, bit 4+i masking `pwm_out[i]`) is low in that same cycle. The fault is latched. Unmasked pairs keep running.
- R6: A latched fault is cleared only by writing 1 to control bit 6 while `fault_in` is low. The masked outputs stay low until the next period boundary. A clear written while `fault_in` is high is ignored.
- R7: The setup register (address 1) accepts only its first write after reset. Later writes have no effect until the next reset.
- R8: With the block running, period and duty writes take effect only at a reload point. A reload point occurs every N periods, where N−1 is control bits 4:1. Each reload sets the reload flag on the clock edge that ends the Nth period.
- R9: The reload flag (`reload_irq`) stays set until a control write with bit 5 = 1 clears it.
- R10: `adc_sync` is high for exactly the first cycle of each PWM period.
- R11: After reset, and whenever control bit 0 (run) is 0, all six outputs are low. After reset, `reload_irq` and `adc_sync` are also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 control, 1 setup, 2 period, 3..5 duty of pairs 0..2 |
| wr_data | input | 11 | Write data |
| fault_in | input | 1 | Active-high external fault |
| pwm_out | output | 6 | Even index top, odd index bottom of each pair |
| reload_irq | output | 1 | Sticky reload flag |
| adc_sync | output | 1 | One-cycle pulse at each period start |

## Verification
Several results have fixed latencies that the bench relies on:
- Fault forcing is combinational, so the bench checks it one time step after raising `fault_in`, within the same cycle.
- The outputs follow the counter through one comparison register, and the dead-time counter runs in parallel with it.
- The reload flag and the new working values both appear on the edge that closes the Nth period. The bench therefore synchronises on the first flag and then checks the flag exactly 39 and 40 cycles later for P = 10 and N = 4.
- The pulse-width results depend on that one-register lag and the dead time. The bench measures them as high-cycle counts over windows that span a whole number of periods in steady state, so the counts do not depend on where the window starts.
- Register writes take effect on the edge that ends the write cycle, and each scenario samples at the falling edge that follows.

// File: rtl/pwm6_pkg.sv
`timescale 1ns/1ps
package pwm6_pkg;
    // Register addresses
    localparam logic [2:0] ADR_CTRL   = 3'd0;
    localparam logic [2:0] ADR_SETUP  = 3'd1;
    localparam logic [2:0] ADR_PERIOD = 3'd2;
    localparam logic [2:0] ADR_DUTY0  = 3'd3;

    // Control register bit positions
    localparam int RUN_B  = 0;
    localparam int RLD_LO = 1;
endpackage

// File: rtl/pwm6_timebase.sv
`timescale 1ns/1ps
module pwm6_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             center,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             period_end
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } tb_t;

    tb_t s_d, s_q;
    logic [CNT_W-1:0] last;

    assign last = period - 1'b1;

    always_comb begin
        s_d        = s_q;
        period_end = 1'b0;
        if (!run) begin
            s_d.cnt  = '0;
            s_d.down = 1'b0;
        end else if (!center) begin
            s_d.down = 1'b0;
            if (s_q.cnt >= last) begin
                period_end = 1'b1;
                s_d.cnt    = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (!s_q.down) begin
            if (s_q.cnt >= last) s_d.down = 1'b1;
            else                 s_d.cnt  = s_q.cnt + 1'b1;
        end else begin
            if (s_q.cnt == '0) begin
                period_end = 1'b1;
                s_d.down   = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !center && period_end) |=> (cnt == '0)); // R1
endmodule

// File: rtl/pwm6_deadband.sv
`timescale 1ns/1ps
module pwm6_deadband #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw,
    input  logic [DT_W-1:0] dt,
    output logic            hi,
    output logic            lo
);
    typedef struct packed {
        logic            lvl;
        logic [DT_W-1:0] age;
    } db_t;

    db_t  s_d, s_q;
    logic settled;

    always_comb begin
        s_d     = s_q;
        s_d.lvl = raw;
        if (raw != s_q.lvl)      s_d.age = '0;
        else if (s_q.age != '1)  s_d.age = s_q.age + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign settled = (s_q.age >= dt);
    assign hi      = s_q.lvl && settled;
    assign lo      = !s_q.lvl && settled;

    AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo)); // R3
    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lo) && dt != '0) |-> !hi); // R3
endmodule

// File: rtl/pwm6_core.sv
`timescale 1ns/1ps
module pwm6_core
    import pwm6_pkg::*;
#(
    parameter int NPAIR = 3,
    parameter int CNT_W = 8,
    parameter int DT_W  = 4,
    parameter int RLD_W = 4,
    localparam int NOUT = 2 * NPAIR,
    localparam int DW   = DT_W + NOUT + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            fault_in,
    output logic [NOUT-1:0] pwm_out,
    output logic            reload_irq,
    output logic            adc_sync
);
    localparam int RLD_HI    = RLD_LO + RLD_W - 1;
    localparam int IRQ_CLR_B = RLD_HI + 1;
    localparam int FLT_CLR_B = RLD_HI + 2;
    localparam int CTR_B     = DT_W + NOUT;

    typedef struct packed {
        logic                         run;
        logic [RLD_W-1:0]             rld_n;
        logic [RLD_W-1:0]             rld_cnt;
        logic                         irq;
        logic                         flt;
        logic                         flt_clr;
        logic                         locked;
        logic [DT_W-1:0]              dt;
        logic [NOUT-1:0]              mask;
        logic                         center;
        logic [CNT_W-1:0]             per_buf;
        logic [CNT_W-1:0]             per_act;
        logic [NPAIR-1:0][CNT_W-1:0]  duty_buf;
        logic [NPAIR-1:0][CNT_W-1:0]  duty_act;
        logic                         sync;
    } core_t;

    core_t            s_d, s_q;
    logic             wr_ctrl, wr_setup, reload, trip;
    logic [CNT_W-1:0] tb_cnt;
    logic             period_end;
    logic [NPAIR-1:0] raw, hi, lo;

    pwm6_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(s_q.run), .center(s_q.center),
        .period(s_q.per_act), .cnt(tb_cnt), .period_end(period_end)
    );

    always_comb begin
        s_d      = s_q;
        wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
        wr_setup = wr_en && (wr_addr == ADR_SETUP);
        if (wr_ctrl) begin
            s_d.run   = wr_data[RUN_B];
            s_d.rld_n = wr_data[RLD_HI:RLD_LO];
        end
        if (wr_setup && !s_q.locked) begin
            s_d.locked = 1'b1;
            s_d.dt     = wr_data[DT_W-1:0];
            s_d.mask   = wr_data[DT_W+NOUT-1:DT_W];
            s_d.center = wr_data[CTR_B];
        end
        if (wr_en && wr_addr == ADR_PERIOD) s_d.per_buf = wr_data[CNT_W-1:0];
        for (int k = 0; k < NPAIR; k++) begin
            if (wr_en && wr_addr == ADR_DUTY0 + 3'(k)) s_d.duty_buf[k] = wr_data[CNT_W-1:0];
        end
        // Working values follow buffers while stopped, else only at reload
        reload = period_end && (s_q.rld_cnt == s_q.rld_n);
        if (!s_q.run) begin
            s_d.per_act  = s_q.per_buf;
            s_d.duty_act = s_q.duty_buf;
            s_d.rld_cnt  = '0;
        end else if (period_end) begin
            if (reload) begin
                s_d.per_act  = s_q.per_buf;
                s_d.duty_act = s_q.duty_buf;
                s_d.rld_cnt  = '0;
            end else begin
                s_d.rld_cnt = s_q.rld_cnt + 1'b1;
            end
        end
        if (wr_ctrl && wr_data[IRQ_CLR_B]) s_d.irq = 1'b0;
        if (reload)                        s_d.irq = 1'b1;
        // Fault latch: clear request honoured at a period boundary
        if (period_end && s_q.flt_clr) begin
            s_d.flt     = 1'b0;
            s_d.flt_clr = 1'b0;
        end
        if (wr_ctrl && wr_data[FLT_CLR_B] && s_q.flt && !fault_in) s_d.flt_clr = 1'b1;
        if (fault_in) begin
            s_d.flt     = 1'b1;
            s_d.flt_clr = 1'b0;
        end
        s_d.sync = period_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trip = s_q.flt | fault_in;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign raw[g] = s_q.run && (tb_cnt < s_q.duty_act[g]);
        pwm6_deadband #(.DT_W(DT_W)) u_db (
            .clk(clk), .rst_n(rst_n), .raw(raw[g]), .dt(s_q.dt),
            .hi(hi[g]), .lo(lo[g])
        );
        assign pwm_out[2*g]   = s_q.run && hi[g] && !(trip && s_q.mask[2*g]);
        assign pwm_out[2*g+1] = s_q.run && lo[g] && !(trip && s_q.mask[2*g+1]);
    end

    assign reload_irq = s_q.irq;
    assign adc_sync   = s_q.sync;

    AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> s_q.flt); // R5
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flt && !period_end) |=> s_q.flt); // R6
    AST_SETUP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.locked && wr_setup) |=> ($stable(s_q.dt) && $stable(s_q.mask) && $stable(s_q.center))); // R7
    AST_ACT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !period_end) |=> ($stable(s_q.per_act) && $stable(s_q.duty_act))); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq && !(wr_ctrl && wr_data[IRQ_CLR_B])) |=> s_q.irq); // R9
    AST_SYNC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sync |-> (tb_cnt == '0)); // R10
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.run |-> (pwm_out == '0)); // R11
endmodule

// File: tb/sim_pwm6_core.sv
`timescale 1ns/1ps
module sim_pwm6_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [10:0] wr_data = '0;
    logic        fault_in = 1'b0;
    logic [5:0]  pwm_out;
    logic        reload_irq, adc_sync;

    int checks = 0;
    int failures = 0;
    int top_c[3];
    int bot_c[3];
    int ov_c, sy_c;

    always #10 clk = ~clk;

    pwm6_core u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fault_in(fault_in), .pwm_out(pwm_out),
        .reload_irq(reload_irq), .adc_sync(adc_sync)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; fault_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = 11'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_win(input int n);
        for (int p = 0; p < 3; p++) begin top_c[p] = 0; bot_c[p] = 0; end
        ov_c = 0; sy_c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int p = 0; p < 3; p++) begin
                top_c[p] += int'(pwm_out[2*p]);
                bot_c[p] += int'(pwm_out[2*p+1]);
                if (pwm_out[2*p] && pwm_out[2*p+1]) ov_c++;
            end
            sy_c += int'(adc_sync);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R11 outputs after reset", int'(pwm_out), 0);
        chk("R11 irq after reset", int'(reload_irq), 0);
        chk("R11 sync after reset", int'(adc_sync), 0);
        wr(1, 2); wr(2, 10); wr(3, 4); wr(4, 0); wr(5, 10);
        count_win(20);
        chk("R11 stopped outputs quiet", top_c[0] + bot_c[0] + top_c[1] + bot_c[1] + top_c[2] + bot_c[2], 0);
    endtask

    task automatic t_edge();
        do_reset();
        wr(1, 2); wr(2, 10); wr(3, 4); wr(4, 0); wr(5, 10);
        wr(0, 1);
        repeat (30) @(negedge clk);
        count_win(50);
        chk("R1 edge top high cycles", top_c[0], 10);
        chk("R1 edge bottom high cycles", bot_c[0], 20);
        chk("R3 no overlap edge", ov_c, 0);
        chk("R4 zero duty top", top_c[1], 0);
        chk("R4 zero duty bottom", bot_c[1], 50);
        chk("R4 full duty top", top_c[2], 50);
        chk("R4 full duty bottom", bot_c[2], 0);
        chk("R10 sync pulses edge", sy_c, 5);
    endtask

    task automatic t_center();
        do_reset();
        wr(1, (1 << 10) | 2); wr(2, 10); wr(3, 4); wr(4, 10); wr(5, 0);
        wr(0, 1);
        repeat (45) @(negedge clk);
        count_win(40);
        chk("R2 center top high cycles", top_c[0], 12);
        chk("R2 center bottom high cycles", bot_c[0], 20);
        chk("R4 center full duty top", top_c[1], 40);
        chk("R3 no overlap center", ov_c, 0);
        chk("R10 sync pulses center", sy_c, 2);
    endtask

    task automatic t_write_once();
        do_reset();
        wr(1, 2);
        wr(1, (63 << 4) | 6);
        wr(2, 10); wr(3, 4);
        wr(0, 1);
        repeat (30) @(negedge clk);
        fault_in = 1'b1;
        count_win(50);
        fault_in = 1'b0;
        chk("R7 second setup ignored top", top_c[0], 10);
        chk("R7 second setup ignored bottom", bot_c[0], 20);
    endtask

    task automatic t_reload();
        int w;
        int tops_a;
        int tops_b;
        do_reset();
        wr(1, 2); wr(2, 10); wr(3, 4);
        wr(0, 7);
        w = 0;
        while (!reload_irq && w < 500) begin @(negedge clk); w++; end
        chk("R8 first reload flag seen", int'(reload_irq), 1);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 11'd39;
        tops_a = 0; tops_b = 0;
        for (int k = 1; k <= 80; k++) begin
            @(negedge clk);
            if (k <= 30) tops_a += int'(pwm_out[0]);
            if (k >= 41) tops_b += int'(pwm_out[0]);
            if (k == 1)  chk("R9 flag cleared by write one", int'(reload_irq), 0);
            if (k == 39) chk("R8 no reload before N periods", int'(reload_irq), 0);
            if (k == 40) chk("R8 reload after N periods", int'(reload_irq), 1);
            if (k == 45) chk("R9 flag sticky", int'(reload_irq), 1);
            wr_en = 1'b0;
            if (k == 5) begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 11'd6; end
        end
        chk("R8 old duty kept before reload", tops_a, 6);
        chk("R8 new duty after reload", tops_b, 16);
    endtask

    task automatic t_fault();
        do_reset();
        wr(1, (3 << 4) | 2); wr(2, 10); wr(3, 4); wr(4, 4);
        wr(0, 1);
        repeat (30) @(negedge clk);
        fault_in = 1'b1;
        #1;
        chk("R5 masked pair forced low same cycle", int'(pwm_out[1:0]), 0);
        count_win(20);
        chk("R5 masked pair low during fault", top_c[0] + bot_c[0], 0);
        chk("R5 unmasked pair keeps running", top_c[1], 4);
        wr(0, 65);
        fault_in = 1'b0;
        count_win(30);
        chk("R6 clear during fault ignored", top_c[0] + bot_c[0], 0);
        wr(0, 65);
        chk("R6 held until period boundary", int'(pwm_out[1:0]), 0);
        repeat (12) @(negedge clk);
        count_win(20);
        chk("R6 resumed top after clear", top_c[0], 4);
        chk("R6 resumed bottom after clear", bot_c[0], 8);
    endtask

    initial begin
        #3000000;
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_edge();
        t_center();
        t_write_once();
        t_reload();
        t_fault();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule